// File: doc/BRIEF.md
# Directory Invalidation Sweep Engine

This block clears the whole coherence directory when software asks for it. It has one 64-bit control register. Software starts a sweep by writing a 1 to bit 0 of that register. The engine then writes "invalid" to every directory entry in turn, at one entry index per clock. While the sweep runs, bit 0 reads back as 1. When the last entry has been cleared, the bit returns to 0 without any software action.

The engine holds off coherent requests for the whole sweep by closing a ready/valid gate on the request path. No request can observe a partly cleared directory, so software can start a sweep and carry on without polling. The register accepts only accesses that are both secure and privileged. Any other access to it is refused and raises an error flag for one cycle. A one-cycle completion pulse is also provided, so that an interrupt can be raised if one is wanted.

Top module: `dir_sweep_ctrl`

## Requirements
- R1: After reset, bit 0 reads 0, no directory entry is written, the done pulse is low and the request gate passes traffic through.
- R2: A secure, privileged write that hits the register address with bit 0 set starts a sweep when no sweep is running. From the next cycle on, bit 0 reads 1 and entry index 0 is written.
- R3: During a sweep, the directory write strobe is high on every cycle. The entry index starts at 0, rises by exactly 1 per cycle and ends at DEPTH-1.
- R4: The cycle after entry DEPTH-1 is written, bit 0 reads 0 and the write strobe is low. The done output is high for that one cycle only.
- R5: Bits 63:1 always read as 0. Writing any value to them starts nothing and changes nothing.
- R6: Writing 1 to bit 0 during a sweep does not restart the index. Writing 0 during a sweep does not stop it.
- R7: A read or write that hits the register while the secure or privileged attribute is low is refused. A refused write has no effect and a refused read returns 0. The error flag is high in the cycle after the access, for one cycle only.
- R8: The request gate forces both ready towards the requester and valid towards the directory low. This holds from the cycle after the starting write through the cycle after bit 0 clears. In every other cycle, ready and valid pass straight through the gate.
- R9: An access to any other address returns read data 0, raises no error and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | AW | Register access address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 64 | Register write data |
| reg_secure | input | 1 | Access is secure |
| reg_priv | input | 1 | Access is privileged |
| reg_rdata | output | 64 | Read data, valid in the same cycle as reg_rd |
| reg_err | output | 1 | One-cycle pulse after a refused access |
| dir_inv_en | output | 1 | Directory entry invalidate strobe |
| dir_inv_idx | output | IW | Index of the entry being invalidated |
| sweep_done | output | 1 | One-cycle pulse when a sweep ends |
| req_valid_in | input | 1 | Coherent request valid from the requester |
| req_ready_out | output | 1 | Ready back to the requester |
| req_valid_out | output | 1 | Request valid towards the directory |
| req_ready_in | input | 1 | Ready from the directory |

## Verification
A cycle model in the bench runs against random register traffic. The random mix varies the address, the secure and privileged attributes, the value of bit 0, values in the reserved bits, and whether a sweep is already running. This mix separates accepted starts from refused, mis-addressed and reserved-only writes. Directed sequences then put a re-trigger write and a zero write into the middle of a sweep. A restarted index or an aborted sweep shows up as a break in the index sequence or an early done pulse. Request valid and ready are toggled at random throughout, so the bench can check the gate both where it closes and where it reopens.

// File: rtl/dsw_pkg.sv
package dsw_pkg;
  localparam int REG_W = 64;

  function automatic logic access_ok(logic secure, logic priv);
    return secure & priv;
  endfunction

  function automatic logic idx_is_last(int idx, int depth);
    return idx == depth - 1;
  endfunction
endpackage

// File: rtl/dsw_regif.sv
module dsw_regif
  import dsw_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] REG_ADDR = 'h80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             wr,
  input  logic             rd,
  input  logic [REG_W-1:0] wdata,
  input  logic             secure,
  input  logic             priv,
  input  logic             busy,
  output logic [REG_W-1:0] rdata,
  output logic             err,
  output logic             start
);
  logic hit, ok, denied_ev;
  logic err_q;

  assign hit       = (addr == REG_ADDR);
  assign ok        = access_ok(secure, priv);
  assign denied_ev = (wr | rd) & hit & ~ok;
  assign start     = wr & hit & ok & wdata[0] & ~busy;

  always_comb begin
    rdata = '0;
    if (rd && hit && ok) rdata[0] = busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= denied_ev;
  end
  assign err = err_q;

  assert_rsvd_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[REG_W-1:1] == '0);
  assert_rsvd_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit && ok && !wdata[0] && (|wdata[REG_W-1:1]) && !busy) |=> !busy);
  assert_denied_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !ok) |-> rdata == '0);
  assert_denied_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    denied_ev |=> err);
  assert_err_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !$past(denied_ev)) |-> 1'b0);
endmodule

// File: rtl/dsw_sweep.sv
module dsw_sweep
  import dsw_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          inv_en,
  output logic [IW-1:0] inv_idx,
  output logic          done
);
  logic          busy_q, done_q;
  logic [IW-1:0] idx_q;
  logic          last_ev;

  assign last_ev = busy_q & idx_is_last(int'(idx_q), DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_ev;
      if (busy_q) begin
        if (last_ev) begin
          busy_q <= 1'b0;
          idx_q  <= '0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end else if (start) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end
    end
  end

  assign busy    = busy_q;
  assign inv_en  = busy_q;
  assign inv_idx = idx_q;
  assign done    = done_q;

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q) |=> (busy_q && idx_q == '0));
  assert_idx_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> idx_q == $past(idx_q) + 1'b1);
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);
  assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_ev) |=> busy_q);
endmodule

// File: rtl/dsw_gate.sv
module dsw_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic vin,
  input  logic rin,
  output logic vout,
  output logic rout
);
  logic hold_q, closed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= busy;
  end

  assign closed = busy | hold_q;
  assign vout   = vin & ~closed;
  assign rout   = rin & ~closed;

  assert_gate_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!vout && !rout));
  assert_gate_tail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!vout && !rout));
endmodule

// File: rtl/dir_sweep_ctrl.sv
module dir_sweep_ctrl
  import dsw_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] REG_ADDR = 'h80,
  parameter int DEPTH = 16,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             reg_secure,
  input  logic             reg_priv,
  output logic [REG_W-1:0] reg_rdata,
  output logic             reg_err,
  output logic             dir_inv_en,
  output logic [IW-1:0]    dir_inv_idx,
  output logic             sweep_done,
  input  logic             req_valid_in,
  output logic             req_ready_out,
  output logic             req_valid_out,
  input  logic             req_ready_in
);
  logic start_ev, busy;

  dsw_regif #(.AW(AW), .REG_ADDR(REG_ADDR)) u_regif (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
    .wdata(reg_wdata), .secure(reg_secure), .priv(reg_priv), .busy(busy),
    .rdata(reg_rdata), .err(reg_err), .start(start_ev)
  );

  dsw_sweep #(.DEPTH(DEPTH), .IW(IW)) u_sweep (
    .clk(clk), .rst_n(rst_n), .start(start_ev), .busy(busy),
    .inv_en(dir_inv_en), .inv_idx(dir_inv_idx), .done(sweep_done)
  );

  dsw_gate u_gate (
    .clk(clk), .rst_n(rst_n), .busy(busy), .vin(req_valid_in),
    .rin(req_ready_in), .vout(req_valid_out), .rout(req_ready_out)
  );
endmodule

// File: tb/dir_sweep_ctrl_tb_top.sv
module dir_sweep_ctrl_tb_top;
  localparam int AW = 16;
  localparam logic [AW-1:0] RA = 'h80;
  localparam int DEPTH = 16;
  localparam int IW = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic reg_wr = 0, reg_rd = 0, reg_secure = 0, reg_priv = 0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic reg_err, dir_inv_en, sweep_done;
  logic [IW-1:0] dir_inv_idx;
  logic req_valid_in = 0, req_ready_out, req_valid_out, req_ready_in = 0;

  int total = 0, bad = 0;
  bit m_busy = 0, m_hold = 0, m_done = 0, m_err = 0;
  int m_idx = 0;

  always #2.5 clk = ~clk;

  dir_sweep_ctrl #(.AW(AW), .REG_ADDR(RA), .DEPTH(DEPTH)) dut_i (.*);

  function automatic logic [63:0] exp_rdata(bit rd, logic [AW-1:0] a, bit s, bit p, bit b);
    return (rd && a == RA && s && p) ? {63'd0, b} : 64'd0;
  endfunction

  task automatic chk(logic [63:0] act, logic [63:0] exp, string req, string ctx);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, ctx, act, exp);
    end
  endtask

  task automatic step(bit wr, bit rd, logic [AW-1:0] a, logic [63:0] wd,
                      bit s, bit p, bit vin, bit rin, string ctx);
    bit hit, ok, start;
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
    reg_secure = s; reg_priv = p; req_valid_in = vin; req_ready_in = rin;
    #1;
    chk(reg_rdata, exp_rdata(rd, a, s, p, m_busy), "R5", ctx);
    chk(64'(reg_err), 64'(m_err), "R7", ctx);
    chk(64'(dir_inv_en), 64'(m_busy), "R3", ctx);
    if (m_busy) chk(64'(dir_inv_idx), 64'(m_idx), "R3", ctx);
    chk(64'(sweep_done), 64'(m_done), "R4", ctx);
    chk(64'(req_ready_out), 64'(rin && !(m_busy || m_hold)), "R8", ctx);
    chk(64'(req_valid_out), 64'(vin && !(m_busy || m_hold)), "R8", ctx);
    @(posedge clk);
    hit = (a == RA); ok = s && p;
    start = wr && hit && ok && wd[0] && !m_busy;
    m_err = (wr || rd) && hit && !ok;
    m_hold = m_busy;
    m_done = 0;
    if (m_busy) begin
      if (m_idx == DEPTH - 1) begin m_busy = 0; m_done = 1; m_idx = 0; end
      else m_idx++;
    end else if (start) begin
      m_busy = 1; m_idx = 0;
    end
    @(negedge clk);
  endtask

  task automatic idle(int n, string ctx);
    for (int k = 0; k < n; k++) step(0, 1, RA, 0, 1, 1, 1, 1, ctx);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    step(0, 1, RA, 0, 1, 1, 1, 1, "R1 reset");
    // R2: start a sweep, observe busy and index 0
    step(1, 0, RA, 64'h1, 1, 1, 1, 1, "R2 trigger");
    step(0, 1, RA, 0, 1, 1, 1, 1, "R2 busy read");
    // R6: re-trigger mid sweep and write 0 mid sweep
    idle(4, "R3 walk");
    step(1, 1, RA, 64'h1, 1, 1, 1, 1, "R6 retrigger");
    step(1, 1, RA, 64'h0, 1, 1, 1, 1, "R6 zero write");
    idle(DEPTH + 3, "R4 end");
    // R5: reserved bits only
    step(1, 0, RA, 64'hFFFF_FFFF_FFFF_FFFE, 1, 1, 1, 1, "R5 reserved write");
    idle(2, "R5 after");
    // R7: refused accesses
    step(1, 0, RA, 64'h1, 0, 1, 1, 1, "R7 nonsecure write");
    step(1, 1, RA, 64'h1, 1, 0, 1, 1, "R7 nonpriv write");
    step(0, 1, RA, 0, 0, 0, 1, 1, "R7 denied read");
    idle(2, "R7 after");
    // R9: other address
    step(1, 1, RA + 1, 64'h1, 1, 1, 1, 1, "R9 other addr");
    idle(2, "R9 after");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] a;
      logic [63:0] wd;
      a = ($urandom_range(0, 9) < 8) ? RA : AW'($urandom);
      wd = {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) wd[0] = 1'b1;
      step(bit'($urandom_range(0, 5) == 0), bit'($urandom), a, wd,
           bit'($urandom_range(0, 5) != 0), bit'($urandom_range(0, 5) != 0),
           bit'($urandom), bit'($urandom), "random");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule